// File: doc/BRIEF.md
# SPI Memory Status and Write-Protection Unit

This unit is the command-side guard logic for a small SPI-attached nonvolatile memory of 512 bytes with 9-bit addresses. It listens on a mode-0 SPI slave port. It decodes the opcodes that arm writes, disarm writes, read the status byte and write the status byte. It keeps a write-enable latch and a two-bit block-protect field. All SPI pins are brought into the system clock domain through a synchronizer chain, and every decision is taken on edges detected in that domain.

An array model outside the unit presents an address with a strobe. The unit answers on a single permit line. The permit is granted only when three conditions hold: the latch is armed, the active-low write-protect pin is high, and the address lies outside the range selected by the block-protect field. The array itself and its data read and write commands are not part of this unit. The unit recognises the array write opcode only so that it can disarm the latch when that cycle ends.

Top module: `spi_wp_unit`

## Requirements
- R1: After the read-status opcode 0x05, the next 8 bits on miso carry the status byte, MSB first, changing after falling SCK edges. Any further bits in the same transaction read 0.
- R2: The status byte holds block-protect bits in positions 3 (upper) and 2 (lower) and the latch flag in position 1. Positions 7:4 and 0 (ready/busy, never busy) always read 0.
- R3: Opcode 0x06 sets the latch and opcode 0x04 clears it. Each takes effect once the eighth opcode bit has been received.
- R4: When chip select rises after a transaction whose opcode was 0x01 (status write) or 0x02 (array write), the latch is cleared. This holds whether or not anything was committed.
- R5: With the latch clear, a status write leaves the block-protect bits unchanged and the permit output stays low.
- R6: While wp_n is low, status writes are discarded and the permit output is low for every address.
- R7: With the latch set and wp_n high, the block-protect field selects the protected addresses. 00 protects none, 01 protects 0x180-0x1FF, 10 protects 0x100-0x1FF, and 11 protects 0x000-0x1FF. The permit is high only outside that range.
- R8: A status write (0x01 followed by one data byte) copies only data bits 3:2 into the block-protect field. The copy happens when chip select rises, and only if all 8 data bits arrived. A shorter byte changes nothing.
- R9: Any other opcode is ignored until chip select rises. It does not change the latch.
- R10: miso_oe is high only while chip select is low. While miso_oe is low, miso is 0.
- R11: After reset the block-protect field is 00 and the latch is 0.
- R12: The permit output is low whenever chk_stb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for miso |
| wp_n | input | 1 | Write-protect pin, active low |
| chk_addr | input | ADDR_W | Array address to be judged |
| chk_stb | input | 1 | Strobe qualifying chk_addr |
| wr_ok | output | 1 | Array write permitted |

## Verification
The assertions assume that SCK is slow against the system clock, with each level held for more than SYNC_STAGES + 1 cycles. They also assume that chip select changes only while SCK is low and that wp_n does not move in the middle of a transaction. Under these conditions every SCK and chip-select edge is seen exactly once. The bench meets this by holding each SCK level and each chip-select setup for six clock cycles. It changes wp_n and the probe address only between transactions, and it waits several cycles after chip select rises before it samples the permit output or starts another transaction.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
   localparam int          BYTE_W     = 8;
   localparam logic [7:0]  OPC_WRSR   = 8'h01;
   localparam logic [7:0]  OPC_WRITE  = 8'h02;
   localparam logic [7:0]  OPC_WRDI   = 8'h04;
   localparam logic [7:0]  OPC_RDSR   = 8'h05;
   localparam logic [7:0]  OPC_WREN   = 8'h06;

   typedef enum logic [1:0] {
      ZONE_NONE    = 2'b00,
      ZONE_QUARTER = 2'b01,
      ZONE_HALF    = 2'b10,
      ZONE_ALL     = 2'b11
   } zone_e;
endpackage

// File: rtl/spi_wp_sync.sv
module spi_wp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   input  logic wp_n,
   output logic cs_act,
   output logic cs_end,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s,
   output logic wp_s
);
   // bit order {cs_n, sck, mosi, wp_n}
   localparam logic [3:0] RST_VAL = 4'b1000;

   logic [STAGES-1:0][3:0] chain;
   logic [3:0]             last_q;
   logic [3:0]             last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_wp_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {STAGES{RST_VAL}};
         last_q <= RST_VAL;
      end else begin
         chain  <= {chain[STAGES-2:0], {cs_n, sck, mosi, wp_n}};
         last_q <= chain[STAGES-1];
      end
   end

   assign last     = chain[STAGES-1];
   assign cs_act   = ~last[3];
   assign cs_end   = last[3] & ~last_q[3];
   assign sck_rise = last[2] & ~last_q[2];
   assign sck_fall = ~last[2] & last_q[2];
   assign mosi_s   = last[1];
   assign wp_s     = last[0];
endmodule

// File: rtl/spi_wp_cmd.sv
module spi_wp_cmd
   import spi_wp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi_s,
   input  logic [BYTE_W-1:0] status,
   output logic              wren_p,
   output logic              wrdi_p,
   output logic              wr_cycle,
   output logic              wrsr_hit,
   output logic              data_full,
   output logic [1:0]        new_bp,
   output logic              miso_bit
);
   localparam int CNT_MAX = 2 * BYTE_W;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] rx, opc, tx;
   logic [BYTE_W-1:0] rx_nxt;
   logic              opc_vld, loaded;

   assign rx_nxt = {rx[BYTE_W-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         rx        <= '0;
         opc       <= '0;
         tx        <= '0;
         opc_vld   <= 1'b0;
         loaded    <= 1'b0;
         data_full <= 1'b0;
         new_bp    <= 2'b00;
         wren_p    <= 1'b0;
         wrdi_p    <= 1'b0;
      end else begin
         wren_p <= 1'b0;
         wrdi_p <= 1'b0;
         if (!cs_act) begin
            cnt       <= '0;
            rx        <= '0;
            opc       <= '0;
            tx        <= '0;
            opc_vld   <= 1'b0;
            loaded    <= 1'b0;
            data_full <= 1'b0;
            new_bp    <= 2'b00;
         end else begin
            if (sck_rise) begin
               rx <= rx_nxt;
               if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(BYTE_W - 1)) begin
                  opc     <= rx_nxt;
                  opc_vld <= 1'b1;
                  wren_p  <= (rx_nxt == OPC_WREN);
                  wrdi_p  <= (rx_nxt == OPC_WRDI);
               end
               if (cnt == CNT_W'(CNT_MAX - 1) && opc == OPC_WRSR) begin
                  new_bp    <= rx_nxt[3:2];
                  data_full <= 1'b1;
               end
            end
            if (sck_fall && opc_vld && opc == OPC_RDSR) begin
               if (!loaded) begin
                  tx     <= status;
                  loaded <= 1'b1;
               end else begin
                  tx <= {tx[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign wrsr_hit = opc_vld & (opc == OPC_WRSR);
   assign wr_cycle = opc_vld & ((opc == OPC_WRSR) | (opc == OPC_WRITE));
   assign miso_bit = tx[BYTE_W-1];
endmodule

// File: rtl/spi_wp_prot.sv
module spi_wp_prot
   import spi_wp_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_s,
   input  logic              cs_end,
   input  logic              wren_p,
   input  logic              wrdi_p,
   input  logic              wr_cycle,
   input  logic              wrsr_hit,
   input  logic              data_full,
   input  logic [1:0]        new_bp,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic              chk_stb,
   output logic              wel,
   output logic [1:0]        bp,
   output logic              wr_ok,
   output logic [BYTE_W-1:0] status
);
   localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1 << (ADDR_W - 1));
   localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'((1 << (ADDR_W - 1)) + (1 << (ADDR_W - 2)));

   zone_e zone;
   logic  in_zone;
   logic  commit;

   assign commit = cs_end & wrsr_hit & data_full & wel & wp_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
         bp  <= 2'b00;
      end else begin
         if (wren_p)                   wel <= 1'b1;
         else if (wrdi_p)              wel <= 1'b0;
         else if (cs_end && wr_cycle)  wel <= 1'b0;
         if (commit) bp <= new_bp;
      end
   end

   assign zone = zone_e'(bp);

   always_comb begin
      case (zone)
         ZONE_NONE:    in_zone = 1'b0;
         ZONE_QUARTER: in_zone = (chk_addr >= QUARTER_BASE);
         ZONE_HALF:    in_zone = (chk_addr >= HALF_BASE);
         default:      in_zone = 1'b1;
      endcase
   end

   assign wr_ok  = chk_stb & wel & wp_s & ~in_zone;
   assign status = {4'b0000, bp, wel, 1'b0};
endmodule

// File: rtl/spi_wp_unit.sv
module spi_wp_unit
   import spi_wp_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              mosi,
   output logic              miso,
   output logic              miso_oe,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic              chk_stb,
   output logic              wr_ok
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("spi_wp_unit: ADDR_W must be at least 2");
      end
   endgenerate

   logic              cs_act, cs_end, sck_rise, sck_fall, mosi_s, wp_s;
   logic              wren_p, wrdi_p, wr_cycle, wrsr_hit, data_full;
   logic [1:0]        new_bp, bp;
   logic              wel, miso_bit;
   logic [BYTE_W-1:0] status;

   spi_wp_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
      .cs_act(cs_act), .cs_end(cs_end), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .mosi_s(mosi_s), .wp_s(wp_s)
   );

   spi_wp_cmd cmd_i (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
      .sck_fall(sck_fall), .mosi_s(mosi_s), .status(status),
      .wren_p(wren_p), .wrdi_p(wrdi_p), .wr_cycle(wr_cycle), .wrsr_hit(wrsr_hit),
      .data_full(data_full), .new_bp(new_bp), .miso_bit(miso_bit)
   );

   spi_wp_prot #(.ADDR_W(ADDR_W)) prot_i (
      .clk(clk), .rst_n(rst_n), .wp_s(wp_s), .cs_end(cs_end), .wren_p(wren_p),
      .wrdi_p(wrdi_p), .wr_cycle(wr_cycle), .wrsr_hit(wrsr_hit),
      .data_full(data_full), .new_bp(new_bp), .chk_addr(chk_addr),
      .chk_stb(chk_stb), .wel(wel), .bp(bp), .wr_ok(wr_ok), .status(status)
   );

   assign miso_oe = cs_act;
   assign miso    = miso_bit & cs_act;
endmodule

// File: rtl/spi_wp_unit_chk.sv
module spi_wp_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wel,
   input logic [1:0] bp,
   input logic       cs_end,
   input logic       wr_cycle,
   input logic       wrsr_hit,
   input logic       wren_p,
   input logic       wrdi_p,
   input logic       wp_s,
   input logic       wr_ok
);
   AST_BP_CHANGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bp) |-> $past(cs_end && wrsr_hit && wel && wp_s)); // R8
   AST_WEL_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(wren_p)); // R3
   AST_WEL_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wel) |-> $past(wrdi_p || (cs_end && wr_cycle))); // R4
   AST_WEL_CLR_END: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && wr_cycle) |=> !wel); // R4
   AST_FULL_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bp == 2'b11) |-> !wr_ok); // R7
   AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_s |-> !wr_ok); // R6
endmodule

bind spi_wp_unit spi_wp_unit_chk chk_i (
   .clk(clk), .rst_n(rst_n), .wel(wel), .bp(bp), .cs_end(cs_end),
   .wr_cycle(wr_cycle), .wrsr_hit(wrsr_hit), .wren_p(wren_p), .wrdi_p(wrdi_p),
   .wp_s(wp_s), .wr_ok(wr_ok)
);

// File: tb/spi_wp_unit_tb_top.sv
module spi_wp_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic       mosi = 1'b0;
   logic       wp_n = 1'b1;
   logic [8:0] chk_addr = '0;
   logic       chk_stb = 1'b0;
   logic       miso, miso_oe, wr_ok;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   spi_wp_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .wp_n(wp_n), .chk_addr(chk_addr),
      .chk_stb(chk_stb), .wr_ok(wr_ok)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [23:0] din, input int nbits, output logic [23:0] dout);
      dout = '0;
      cs_n = 1'b0;
      wait_clk(6);
      for (int i = 0; i < nbits; i++) begin
         mosi = din[23-i];
         wait_clk(6);
         dout = {dout[22:0], miso};
         sck  = 1'b1;
         wait_clk(6);
         sck  = 1'b0;
      end
      wait_clk(6);
      cs_n = 1'b1;
      mosi = 1'b0;
      wait_clk(10);
   endtask

   task automatic cmd(input logic [7:0] opc);
      logic [23:0] d;
      xfer({opc, 16'h0}, 8, d);
   endtask

   task automatic wrsr(input logic [7:0] val, input int nbits);
      logic [23:0] d;
      xfer({8'h01, val, 8'h00}, nbits, d);
   endtask

   task automatic rdsr(output logic [7:0] st, output logic [7:0] tail);
      logic [23:0] d;
      xfer({8'h05, 16'h0}, 24, d);
      st   = d[15:8];
      tail = d[7:0];
   endtask

   function automatic logic exp_ok(input logic [1:0] b, input logic [8:0] a);
      case (b)
         2'b00:   return 1'b1;
         2'b01:   return a < 9'h180;
         2'b10:   return a < 9'h100;
         default: return 1'b0;
      endcase
   endfunction

   task automatic t_reset();
      logic [7:0] st, tl;
      check("R10 idle oe", miso_oe, 0);
      check("R10 idle miso", miso, 0);
      chk_stb = 1'b1; chk_addr = 9'h000; wait_clk(2);
      check("R11 permit after reset", wr_ok, 0);
      chk_stb = 1'b0;
      rdsr(st, tl);
      check("R11 status after reset", st, 8'h00);
   endtask

   task automatic t_oe_during();
      cs_n = 1'b0; wait_clk(6);
      check("R10 oe with cs low", miso_oe, 1);
      cs_n = 1'b1; wait_clk(10);
      check("R10 oe after cs high", miso_oe, 0);
   endtask

   task automatic t_wren_wrdi();
      logic [7:0] st, tl;
      cmd(8'h06);
      rdsr(st, tl);
      check("R3 wren sets latch, R2 bit1", st, 8'h02);
      check("R1 trailing bits zero", tl, 8'h00);
      rdsr(st, tl);
      check("R3 latch kept over status read", st, 8'h02);
      cmd(8'h04);
      rdsr(st, tl);
      check("R3 wrdi clears latch", st, 8'h00);
   endtask

   task automatic t_no_wel();
      logic [7:0] st, tl;
      wrsr(8'hFF, 16);
      rdsr(st, tl);
      check("R5 status write without latch", st, 8'h00);
      chk_stb = 1'b1; chk_addr = 9'h010; wait_clk(2);
      check("R5 permit without latch", wr_ok, 0);
      chk_stb = 1'b0;
   endtask

   task automatic t_wp_low();
      logic [7:0] st, tl;
      cmd(8'h06);
      wp_n = 1'b0; wait_clk(6);
      chk_stb = 1'b1; chk_addr = 9'h000; wait_clk(2);
      check("R6 permit with wp low", wr_ok, 0);
      chk_stb = 1'b0;
      wrsr(8'hFF, 16);
      wp_n = 1'b1; wait_clk(6);
      rdsr(st, tl);
      check("R6 status write blocked, R4 latch cleared", st, 8'h00);
   endtask

   task automatic t_wrsr_ok();
      logic [7:0] st, tl;
      cmd(8'h06);
      wrsr(8'hFF, 16);
      rdsr(st, tl);
      check("R8 only bits 3:2 taken, R4 latch cleared", st, 8'h0C);
      cmd(8'h06);
      wrsr(8'h00, 12);
      rdsr(st, tl);
      check("R8 truncated byte ignored, R4 latch cleared", st, 8'h0C);
      cmd(8'h06);
      wrsr(8'hF3, 16);
      rdsr(st, tl);
      check("R8 other bits ignored", st, 8'h00);
   endtask

   task automatic t_zones();
      logic [7:0] st, tl;
      logic [8:0] probes [6] = '{9'h000, 9'h0FF, 9'h100, 9'h17F, 9'h180, 9'h1FF};
      for (int b = 0; b < 4; b++) begin
         cmd(8'h06);
         wrsr({4'h0, 2'(b), 2'b00}, 16);
         cmd(8'h06);
         rdsr(st, tl);
         check("R2 status layout", st, {4'h0, 2'(b), 2'b10});
         for (int p = 0; p < 6; p++) begin
            chk_addr = probes[p]; chk_stb = 1'b1; wait_clk(2);
            check($sformatf("R7 zone %0d addr %0h", b, probes[p]), wr_ok, exp_ok(2'(b), probes[p]));
         end
         chk_stb = 1'b0; wait_clk(2);
         check("R12 permit with strobe low", wr_ok, 0);
         wp_n = 1'b0; chk_stb = 1'b1; chk_addr = 9'h000; wait_clk(6);
         check("R6 wp low blocks array", wr_ok, 0);
         wp_n = 1'b1; chk_stb = 1'b0; wait_clk(6);
         cmd(8'h04);
      end
      cmd(8'h06);
      wrsr(8'h00, 16);
   endtask

   task automatic t_write_cycle();
      logic [7:0] st, tl;
      logic [23:0] d;
      cmd(8'h06);
      xfer({8'h02, 16'h0000}, 17, d);
      rdsr(st, tl);
      check("R4 array write cycle clears latch", st, 8'h00);
   endtask

   task automatic t_unknown();
      logic [7:0] st, tl;
      logic [23:0] d;
      cmd(8'h06);
      xfer({8'hAB, 8'hFF, 8'h00}, 16, d);
      rdsr(st, tl);
      check("R9 unknown opcode ignored", st, 8'h02);
      cmd(8'h04);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_oe_during();
      t_wren_wrdi();
      t_no_wel();
      t_wp_low();
      t_wrsr_ok();
      t_zones();
      t_write_cycle();
      t_unknown();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule